// File: doc/BRIEF.md
# External Interrupt Edge Controller

This block collects five external interrupt pins and turns selected transitions on them into latched request flags. Each pin first passes through its own synchroniser. A per-pin polarity bit then chooses whether a rising or a falling transition counts as an event. When an event is seen, the pin's flag is set and stays set until software clears it.

Software reaches the block through a small byte-wide register bus. The bus has a write strobe and a combinational read port. Through it, software sets the polarity bits and the per-source enables, and it reads the flags. A flag is cleared by writing 0 to its bit. Software cannot set a flag.

The block drives one combined interrupt output. That output is high while any flag is set and its enable bit is also set.

Top module: `extint_top`

## Requirements
- R1: Edge-select register (offset 0x2) bits 4..0 pick the polarity for pins 4..0. A bit value of 0 latches a flag on a falling transition of the pin, and 1 latches a flag on a rising transition. The other transition of that pin sets nothing. All five bits reset to 0.
- R2: Reads of the edge-select register return 0 in bit 7 and 1 in bits 6 and 5, whatever is written to those bits. The register therefore reads 0x60 after reset, and 0x7F after 0xFF is written to it.
- R3: A selected transition on a pin, held stable, makes its flag readable at the third rising clock edge after the pin changes, and not at the first or second.
- R4: In request register 1 (offset 0x6), bits 4..0 are the flags for pins 4..0. Writing 0 to a flag bit clears it. Writing 1 leaves it as it is, so a cleared flag is never set by software.
- R5: When a clearing write and a new event on the same pin reach the same clock edge, the flag ends up set.
- R6: Bits 7..5 of request register 1 read as 001 at all times (reset value 0x20) and ignore writes.
- R7: The interrupt output is 1 exactly while some flag in request register 1 bits 4..0 is 1 and the same bit of enable register 1 is 1.
- R8: Writing the edge-select register while the pin level is steady never sets a flag, whichever polarity is written.
- R9: Enable register 1 (offset 0x3) holds bits 4..0 read/write, reads 0 in bits 7..5, and resets to 0x00. Enable register 2 (offset 0x4) is an 8-bit read/write register that resets to 0x01.
- R10: Request register 2 (offset 0x7) resets to 0x03 and only accepts writes that clear bits to 0. The wakeup request register (offset 0x9) always reads 0x00.
- R11: Reads of any offset other than 0x2, 0x3, 0x4, 0x6, 0x7 and 0x9 return 0x00. Writes to those offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| extPin | input | 5 | Asynchronous external interrupt pins, bit i is pin i |
| busAddr | input | 4 | Register offset for reads and writes |
| busWrEn | input | 1 | Write strobe, one write per clock while high |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for busAddr, combinational |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is the collision between a software clear and a fresh event on the same pin. The event only reaches the flag logic after the synchroniser and edge stage, so the bench changes the pin level and then holds the clearing write back by exactly two clock edges. That places both at the same edge.

A second subtle case is a polarity change while the pin sits high or low. The bench holds a pin steady, flips its select bit both ways, and confirms that no flag appears.

A behavioural model in the bench tracks every register and the delayed pin samples. It is compared with the read port and the interrupt output on every cycle.

// File: rtl/extint_pkg.sv
package extint_pkg;

  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 4;
  localparam int NUM_SRC = 5;

  // register offsets; software depends on these
  localparam logic [ADDR_W-1:0] OFS_EDGE = 4'h2;
  localparam logic [ADDR_W-1:0] OFS_EN1  = 4'h3;
  localparam logic [ADDR_W-1:0] OFS_EN2  = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_REQ1 = 4'h6;
  localparam logic [ADDR_W-1:0] OFS_REQ2 = 4'h7;
  localparam logic [ADDR_W-1:0] OFS_WAKE = 4'h9;

  // fixed upper bits of the registers with five live bits
  localparam logic [DATA_W-NUM_SRC-1:0] EDGE_FIXED = 3'b011;
  localparam logic [DATA_W-NUM_SRC-1:0] REQ1_FIXED = 3'b001;
  localparam logic [DATA_W-NUM_SRC-1:0] EN1_FIXED  = 3'b000;

  localparam logic [DATA_W-1:0] EN2_RESET  = 8'h01;
  localparam logic [DATA_W-1:0] REQ2_RESET = 8'h03;
  localparam logic [DATA_W-1:0] WAKE_VALUE = 8'h00;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_EDGE, SEL_EN1, SEL_EN2, SEL_REQ1, SEL_REQ2, SEL_WAKE
  } rdSel_t;

  typedef struct packed {
    logic   wrEdge;
    logic   wrEn1;
    logic   wrEn2;
    logic   wrReq1;
    logic   wrReq2;
    rdSel_t rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output ctrlStrobe_t       strobe
);

  rdSel_t selNow;

  always_comb begin
    unique case (busAddr)
      OFS_EDGE: selNow = SEL_EDGE;
      OFS_EN1:  selNow = SEL_EN1;
      OFS_EN2:  selNow = SEL_EN2;
      OFS_REQ1: selNow = SEL_REQ1;
      OFS_REQ2: selNow = SEL_REQ2;
      OFS_WAKE: selNow = SEL_WAKE;
      default:  selNow = SEL_NONE;
    endcase
  end

  always_comb begin
    strobe        = '0;
    strobe.rdSel  = selNow;
    strobe.wrEdge = busWrEn && (selNow == SEL_EDGE);
    strobe.wrEn1  = busWrEn && (selNow == SEL_EN1);
    strobe.wrEn2  = busWrEn && (selNow == SEL_EN2);
    strobe.wrReq1 = busWrEn && (selNow == SEL_REQ1);
    strobe.wrReq2 = busWrEn && (selNow == SEL_REQ2);
  end

  // R11: at most one register written per cycle, none when the offset is unmapped
  a_r11_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.wrEdge, strobe.wrEn1, strobe.wrEn2, strobe.wrReq1, strobe.wrReq2}));

  a_r11_unmapped_quiet: assert property (@(posedge clk) disable iff (rst)
    (strobe.rdSel == SEL_NONE) |->
      ({strobe.wrEdge, strobe.wrEn1, strobe.wrEn2, strobe.wrReq1, strobe.wrReq2} == '0));

endmodule

// File: rtl/extint_datapath.sv
module extint_datapath
  import extint_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] pinIn,
  input  logic [DATA_W-1:0]  wrData,
  input  ctrlStrobe_t        strobe,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqOut
);

  localparam int FIXED_W = DATA_W - NUM_SRC;

  logic [NUM_SRC-1:0] syncLvl;
  logic [NUM_SRC-1:0] edgeSelQ;
  logic [NUM_SRC-1:0] en1Q;
  logic [DATA_W-1:0]  en2Q;
  logic [NUM_SRC-1:0] req1Flags;
  logic [DATA_W-1:0]  req2Q;
  logic [NUM_SRC-1:0] prevNorm;
  logic [NUM_SRC-1:0] normNow;
  logic [NUM_SRC-1:0] detEdge;
  logic [NUM_SRC-1:0] clearMask;

  // per-pin synchroniser chains
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[SYNC_STAGES-2:0], pinIn[i]};
    end
    assign syncLvl[i] = chain[SYNC_STAGES-1];
  end

  // polarity-normalised level: 1 means "active side" for the chosen edge
  assign normNow = syncLvl ^ ~edgeSelQ;
  assign detEdge = normNow & ~prevNorm;

  always_ff @(posedge clk) begin
    if (rst) begin
      prevNorm <= ~'0;   // sync level 0 under falling polarity is "active"
    end else if (strobe.wrEdge) begin
      // re-base against the new polarity so the flip itself is no event
      prevNorm <= syncLvl ^ ~wrData[NUM_SRC-1:0];
    end else begin
      prevNorm <= normNow;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) edgeSelQ <= '0;
    else if (strobe.wrEdge) edgeSelQ <= wrData[NUM_SRC-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) en1Q <= '0;
    else if (strobe.wrEn1) en1Q <= wrData[NUM_SRC-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) en2Q <= EN2_RESET;
    else if (strobe.wrEn2) en2Q <= wrData;
  end

  assign clearMask = strobe.wrReq1 ? wrData[NUM_SRC-1:0] : '1;

  // set has priority over a simultaneous clear
  always_ff @(posedge clk) begin
    if (rst) req1Flags <= '0;
    else     req1Flags <= (req1Flags & clearMask) | detEdge;
  end

  always_ff @(posedge clk) begin
    if (rst) req2Q <= REQ2_RESET;
    else if (strobe.wrReq2) req2Q <= req2Q & wrData;
  end

  always_comb begin
    unique case (strobe.rdSel)
      SEL_EDGE: rdData = {EDGE_FIXED, edgeSelQ};
      SEL_EN1:  rdData = {EN1_FIXED, en1Q};
      SEL_EN2:  rdData = en2Q;
      SEL_REQ1: rdData = {REQ1_FIXED, req1Flags};
      SEL_REQ2: rdData = req2Q;
      SEL_WAKE: rdData = WAKE_VALUE;
      default:  rdData = '0;
    endcase
  end

  assign irqOut = |(req1Flags & en1Q);

  // R4: a flag only rises when an event was detected on the previous edge
  a_r4_no_sw_set: assert property (@(posedge clk) disable iff (rst)
    ((req1Flags & ~$past(req1Flags) & ~$past(detEdge)) == '0));

  // R5: a detected event always leaves its flag set, even under a clear
  a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
    (detEdge != '0) |=> ((req1Flags & $past(detEdge)) == $past(detEdge)));

  // R7: output rises only after an enabled event or an enable write
  a_r7_irq_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(irqOut) |-> (($past(detEdge & en1Q) != '0) || $past(strobe.wrEn1)));

  // R10: request register 2 bits never go from 0 to 1
  a_r10_req2_no_set: assert property (@(posedge clk) disable iff (rst)
    ((req2Q & ~$past(req2Q)) == '0));

  // R2: bits above the select field are not storage
  a_r2_fixed_bits: assert property (@(posedge clk) disable iff (rst)
    (strobe.rdSel == SEL_EDGE) |-> (rdData[DATA_W-1:NUM_SRC] == EDGE_FIXED));

  if (FIXED_W < 1) begin : g_bad_width
    initial $display("data width must exceed the source count");
  end

endmodule

// File: rtl/extint_top.sv
module extint_top
  import extint_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] extPin,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [DATA_W-1:0]  busWrData,
  output logic [DATA_W-1:0]  busRdData,
  output logic               irqOut
);

  ctrlStrobe_t strobe;

  extint_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobe  (strobe)
  );

  extint_datapath #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .pinIn  (extPin),
    .wrData (busWrData),
    .strobe (strobe),
    .rdData (busRdData),
    .irqOut (irqOut)
  );

endmodule

// File: tb/sim_extint_top.sv
module sim_extint_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] extPin = '0;
  logic [3:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       irqOut;

  int total = 0;
  int bad   = 0;
  bit live  = 1'b0;

  always #4 clk = ~clk;

  extint_top u0 (
    .clk(clk), .rst(rst), .extPin(extPin), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData), .irqOut(irqOut)
  );

  // behavioural reference
  logic [4:0] mEdge, mEn1, mReq1, ms1, ms2, mPrev;
  logic [7:0] mEn2, mReq2;

  always @(posedge clk) begin
    logic [4:0] det;
    if (rst) begin
      mEdge = 0; mEn1 = 0; mReq1 = 0; mEn2 = 8'h01; mReq2 = 8'h03;
      ms1 = 0; ms2 = 0; mPrev = 0;
    end else begin
      for (int i = 0; i < 5; i++)
        det[i] = mEdge[i] ? (ms2[i] & ~mPrev[i]) : (~ms2[i] & mPrev[i]);
      if (busWrEn) begin
        case (busAddr)
          4'h2: mEdge = busWrData[4:0];
          4'h3: mEn1  = busWrData[4:0];
          4'h4: mEn2  = busWrData;
          4'h6: mReq1 = mReq1 & busWrData[4:0];
          4'h7: mReq2 = mReq2 & busWrData;
          default: ;
        endcase
      end
      mReq1 = mReq1 | det;
      mPrev = ms2; ms2 = ms1; ms1 = extPin;
    end
  end

  function automatic logic [7:0] mRead(logic [3:0] a);
    case (a)
      4'h2: return {3'b011, mEdge};
      4'h3: return {3'b000, mEn1};
      4'h4: return mEn2;
      4'h6: return {3'b001, mReq1};
      4'h7: return mReq2;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tagFor(logic [3:0] a);
    case (a)
      4'h2: return "R2";
      4'h3, 4'h4: return "R9";
      4'h6: return "R6";
      4'h7, 4'h9: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (live && !rst) begin
      check8(tagFor(busAddr), busRdData, mRead(busAddr));
      check8("R7", {7'b0, irqOut}, {7'b0, |(mReq1 & mEn1)});
    end
  end

  task automatic wrReg(logic [3:0] a, logic [7:0] d);
    @(negedge clk); #1;
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic rdChk(logic [3:0] a, logic [7:0] exp, string tag);
    @(negedge clk); #1;
    busAddr = a;
    @(negedge clk);
    check8(tag, busRdData, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic irqChk(logic exp);
    @(negedge clk);
    check8("R7", {7'b0, irqOut}, {7'b0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog R1..all actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    live = 1'b1;

    // reset values and the map
    rdChk(4'h2, 8'h60, "R2 R1 reset");
    rdChk(4'h3, 8'h00, "R9 en1 reset");
    rdChk(4'h4, 8'h01, "R9 en2 reset");
    rdChk(4'h6, 8'h20, "R6 req1 reset");
    rdChk(4'h7, 8'h03, "R10 req2 reset");
    rdChk(4'h9, 8'h00, "R10 wake");
    rdChk(4'h5, 8'h00, "R11 gap");
    rdChk(4'hF, 8'h00, "R11 top");
    check8("R7 reset", {7'b0, irqOut}, 8'h00);

    // fixed bits of edge select
    wrReg(4'h2, 8'hFF);
    rdChk(4'h2, 8'h7F, "R2 all ones");
    wrReg(4'h2, 8'h00);
    rdChk(4'h2, 8'h60, "R2 cleared");

    // latency of a falling event on pin 0
    extPin[0] = 1'b1;
    idle(5);
    rdChk(4'h6, 8'h20, "R1 rise ignored under falling select");
    @(negedge clk); #1;
    busAddr = 4'h6; extPin[0] = 1'b0;
    @(negedge clk); check8("R3 edge1", busRdData, 8'h20);
    @(negedge clk); check8("R3 edge2", busRdData, 8'h20);
    @(negedge clk); check8("R3 edge3", busRdData, 8'h21);

    // clear semantics
    wrReg(4'h6, 8'hFF);
    rdChk(4'h6, 8'h21, "R4 write one keeps");
    wrReg(4'h6, 8'hFE);
    rdChk(4'h6, 8'h20, "R4 write zero clears");
    wrReg(4'h6, 8'hFF);
    rdChk(4'h6, 8'h20, "R4 no software set");

    // rising select on pin 2
    wrReg(4'h2, 8'h04);
    extPin[2] = 1'b1;
    idle(5);
    rdChk(4'h6, 8'h24, "R1 rising select");
    wrReg(4'h6, 8'hFB);
    extPin[2] = 1'b0;
    idle(5);
    rdChk(4'h6, 8'h20, "R1 fall ignored under rising select");

    // polarity flips while pin 3 is steady high
    extPin[3] = 1'b1;
    idle(5);
    wrReg(4'h2, 8'h0C);
    idle(4);
    rdChk(4'h6, 8'h20, "R8 flip to rising");
    wrReg(4'h2, 8'h04);
    idle(4);
    rdChk(4'h6, 8'h20, "R8 flip to falling");
    extPin[3] = 1'b0;
    idle(5);
    rdChk(4'h6, 8'h28, "R1 pin3 falling");
    wrReg(4'h6, 8'hF7);

    // clear and event on the same edge
    extPin[4] = 1'b1;
    idle(5);
    @(negedge clk); #1;
    extPin[4] = 1'b0;
    @(negedge clk); #1;
    @(negedge clk); #1;
    busAddr = 4'h6; busWrData = 8'h00; busWrEn = 1'b1;
    @(negedge clk); #1;
    busWrEn = 1'b0;
    rdChk(4'h6, 8'h30, "R5 set beats clear");
    wrReg(4'h6, 8'hEF);
    rdChk(4'h6, 8'h20, "R4 clear pin4");

    // combined output
    irqChk(1'b0);
    wrReg(4'h3, 8'h10);
    irqChk(1'b0);
    extPin[4] = 1'b1;
    idle(5);
    extPin[4] = 1'b0;
    idle(5);
    irqChk(1'b1);
    wrReg(4'h3, 8'h00);
    irqChk(1'b0);
    wrReg(4'h3, 8'hFF);
    rdChk(4'h3, 8'h1F, "R9 en1 width");
    irqChk(1'b1);
    wrReg(4'h6, 8'hEF);
    irqChk(1'b0);

    // second enable register
    wrReg(4'h4, 8'hA5);
    rdChk(4'h4, 8'hA5, "R9 en2 a5");
    wrReg(4'h4, 8'h5A);
    rdChk(4'h4, 8'h5A, "R9 en2 5a");

    // request 2 and wakeup
    wrReg(4'h7, 8'hFF);
    rdChk(4'h7, 8'h03, "R10 req2 ones keep");
    wrReg(4'h7, 8'hFE);
    rdChk(4'h7, 8'h02, "R10 req2 clear bit0");
    wrReg(4'h9, 8'hFF);
    rdChk(4'h9, 8'h00, "R10 wake fixed");

    // upper bits of request 1
    wrReg(4'h6, 8'h00);
    rdChk(4'h6, 8'h20, "R6 upper bits zero write");
    wrReg(4'h6, 8'hDF);
    rdChk(4'h6, 8'h20, "R6 upper bits mixed write");

    // unmapped writes
    wrReg(4'h5, 8'hFF);
    wrReg(4'h8, 8'hFF);
    wrReg(4'h0, 8'hFF);
    wrReg(4'h1, 8'h00);
    rdChk(4'h5, 8'h00, "R11 read after write");
    rdChk(4'h3, 8'h1F, "R11 en1 untouched");
    rdChk(4'h4, 8'h5A, "R11 en2 untouched");
    rdChk(4'h2, 8'h64, "R11 edge untouched");
    rdChk(4'h7, 8'h02, "R11 req2 untouched");

    live = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule